// File: doc/BRIEF.md
# System Clock Ratio and Word-Clock Sync Monitor

This block sits in the clock section of an audio converter that runs in slave mode. The system clock and the word clock both come from outside. The monitor counts system clock cycles between rising edges of the word clock. From that count it decides whether the system clock runs at 256, 384, 512 or 768 times the sample rate. Once it has accepted a ratio, it produces a processing enable that fires exactly 256 times per sample period. Downstream filters therefore always see one effective rate, whatever the incoming ratio.

After lock, every word-clock period is compared with the nominal period for the accepted ratio. The difference is converted to bit-clock units, using a frame of 64 or 48 bit clocks. A drift beyond the loss limit drops the lock, stops the enable and mutes the sample output. The monitor then waits for a period whose drift is inside a tighter resync limit. The output stays muted for a further 32 sample periods before normal data is released. No fixed phase between the two clocks is required, only a stable frequency relationship. The word clock is taken as already synchronous to the system clock.

Top module: `clkratio_sync_mon`

## Requirements
- R1: While reset is low and on the first cycle after it, `locked` is 0, `force_zero` is 1, `proc_en` is 0 and `ratio_code` is 0.
- R2: A measured period within plus or minus 2 cycles of 256, 384, 512 or 768 is classed as ratio code 0, 1, 2 or 3. A ratio is accepted only when two consecutive measured periods fall in the same class. A period outside every window, or periods that alternate between classes, never cause lock.
- R3: While `locked` is 1 and the frame length is exact, `proc_en` is high on exactly 256 cycles of every word-clock period for each of the four ratios. While `locked` is 0 it stays low.
- R4: After a ratio is accepted, `force_zero` stays 1 through the next 31 word-clock rising edges. It falls to 0 on the 32nd.
- R5: With 64-bit frames, a measured period that differs from nominal by more than 6 bit clocks (|drift| x 64 > 6 x nominal) clears `locked` and sets `force_zero` one cycle after the edge. A drift of exactly 6 bit clocks leaves the output running. Short and long periods are treated alike.
- R6: With 48-bit frames (`short_frame` = 1), the loss limit is 5 bit clocks (|drift| x 48 > 5 x nominal).
- R7: A missing word-clock edge is detected without waiting for the next edge. Once the running count exceeds nominal by more than the loss limit, lock is dropped.
- R8: While unlocked after a loss, a period whose drift is below 5 bit clocks (64-bit frames) or 4 bit clocks (48-bit frames) restores `locked` with `force_zero` held. A period between the two limits leaves the monitor unlocked.
- R9: The accepted `ratio_code` is held unchanged through loss of sync and resynchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_clk | input | 1 | Word clock, synchronous to `clk` |
| short_frame | input | 1 | 1: 48 bit clocks per frame, 0: 64 |
| ratio_code | output | 2 | Accepted ratio: 0=256x, 1=384x, 2=512x, 3=768x |
| locked | output | 1 | Ratio accepted and word clock in sync |
| force_zero | output | 1 | Force sample output to zero |
| proc_en | output | 1 | 256x-rate processing enable |

## Verification
The bench puts periods on both sides of each threshold: 280 against 281 and 232 against 231 cycles at 256x with 64-bit frames, and 282 against 283 with 48-bit frames. A monitor with an off-by-one compare would drop lock on a tolerable drift, or miss a real one. Resync is tried with a period between the two limits and then one just inside. A monitor using the loss limit for resync would recover too early. The ratio windows are probed at 258 and 259 cycles and with alternating classes, to catch premature acceptance. The enable is counted per frame at all four ratios, so a wrong divide pattern for 384x or 768x shows up as a count other than 256. A stalled word clock checks that a monitor waiting for the next edge does not stay locked.

// File: rtl/csm_pkg.sv
// Shared definitions for the clock ratio and sync monitor.
// Assumes ratios are expressed as multiples of a base of 256 cycles.
package csm_pkg;

    typedef enum logic [1:0] {
        ST_ACQ  = 2'd0,
        ST_ZERO = 2'd1,
        ST_RUN  = 2'd2,
        ST_LOST = 2'd3
    } mon_state_e;

    localparam logic [1:0] RT_256 = 2'd0;
    localparam logic [1:0] RT_384 = 2'd1;
    localparam logic [1:0] RT_512 = 2'd2;
    localparam logic [1:0] RT_768 = 2'd3;

    // Nominal system clock cycles per word-clock period for a ratio code.
    function automatic int unsigned nominal_count(input int unsigned base,
                                                  input logic [1:0] code);
        case (code)
            RT_256:  return base;
            RT_384:  return (base * 3) / 2;
            RT_512:  return base * 2;
            default: return base * 3;
        endcase
    endfunction

endpackage

// File: rtl/csm_ratio_classify.sv
// Classifies a measured word-clock period into one of four ratio windows.
// Assumes the windows (nominal plus or minus TOL) do not overlap.
module csm_ratio_classify
    import csm_pkg::*;
#(
    parameter int unsigned BASE  = 256,
    parameter int unsigned TOL   = 2,
    parameter int unsigned CNT_W = 11
) (
    input  logic [CNT_W-1:0] period,
    output logic             hit,
    output logic [1:0]       code
);

    logic [3:0] match;

    // One comparator pair per supported ratio.
    for (genvar k = 0; k < 4; k++) begin : g_win
        localparam int unsigned NOM = nominal_count(BASE, 2'(k));
        localparam int unsigned LO  = NOM - TOL;
        localparam int unsigned HI  = NOM + TOL;
        assign match[k] = (period >= CNT_W'(LO)) && (period <= CNT_W'(HI));
    end

    // Encode the matching window into a ratio code.
    always_comb begin
        code = 2'd0;
        for (int k = 0; k < 4; k++) begin
            if (match[k]) code = 2'(k);
        end
        hit = |match;
    end

    // Windows must be disjoint so at most one ratio matches.
    always_comb begin
        if (!$isunknown(period)) begin
            AST_WINDOWS_DISJOINT: assert ($onehot0(match)); // R2
        end
    end

endmodule

// File: rtl/csm_drift_judge.sv
// Converts the difference between a cycle count and the nominal period
// into bit-clock units and compares it with the loss and resync limits.
// Assumes count is the cycles since the last word-clock rise.
module csm_drift_judge
    import csm_pkg::*;
#(
    parameter int unsigned BASE   = 256,
    parameter int unsigned CNT_W  = 11,
    parameter int unsigned LOSS64 = 6,
    parameter int unsigned SYNC64 = 5,
    parameter int unsigned LOSS48 = 5,
    parameter int unsigned SYNC48 = 4
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       code,
    input  logic             short_frame,
    output logic             exceed,
    output logic             calm,
    output logic             late
);

    logic [31:0] nom;
    logic [31:0] cnt32;
    logic [31:0] dabs;
    logic [31:0] lhs;
    logic [31:0] loss_rhs;
    logic [31:0] calm_rhs;

    // Scale |count - nominal| by frame length and compare with limit x nominal.
    always_comb begin
        nom      = 32'(nominal_count(BASE, code));
        cnt32    = 32'(count);
        dabs     = (cnt32 >= nom) ? (cnt32 - nom) : (nom - cnt32);
        lhs      = dabs * (short_frame ? 32'd48 : 32'd64);
        loss_rhs = nom * (short_frame ? LOSS48 : LOSS64);
        calm_rhs = nom * (short_frame ? SYNC48 : SYNC64);
        exceed   = lhs > loss_rhs;
        calm     = lhs < calm_rhs;
        late     = cnt32 > nom;
    end

    // The loss band and the resync band never overlap.
    always_comb begin
        if (!$isunknown(count)) begin
            AST_BANDS_DISJOINT: assert (!(exceed && calm)); // R8
        end
    end

endmodule

// File: rtl/csm_rate_enable.sv
// Produces a 256-per-frame enable from the system clock for the accepted ratio.
// Assumes the divider phase may be realigned at every word-clock rise.
module csm_rate_enable
    import csm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       active,
    input  logic [1:0] code,
    output logic       proc_en
);

    logic [1:0] ph;
    logic [1:0] ph_next;
    logic [1:0] modulus;
    logic       pat;

    // Next divider phase and the keep/drop pattern for this ratio.
    always_comb begin
        case (code)
            RT_256:  modulus = 2'd1;
            RT_512:  modulus = 2'd2;
            default: modulus = 2'd3;
        endcase
        if (rise || (ph >= modulus - 2'd1)) ph_next = 2'd0;
        else                                ph_next = ph + 2'd1;
        case (code)
            RT_256:  pat = 1'b1;
            RT_384:  pat = (ph_next != 2'd2);
            default: pat = (ph_next == 2'd0);
        endcase
    end

    // Register the phase and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= 2'd0;
            proc_en <= 1'b0;
        end else begin
            ph      <= ph_next;
            proc_en <= active && pat;
        end
    end

    // Enable never fires on the cycle after the block was inactive.
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !proc_en); // R3

endmodule

// File: rtl/clkratio_sync_mon.sv
// Slave-mode system clock ratio detector and word-clock sync monitor.
// Measures cycles per word-clock period, accepts a ratio after two matching
// frames, mutes output for a fixed number of frames after lock, and drops
// lock when drift passes the loss limit. Assumes word_clk is synchronous
// to clk.
module clkratio_sync_mon
    import csm_pkg::*;
#(
    parameter int unsigned BASE        = 256,
    parameter int unsigned TOL         = 2,
    parameter int unsigned ZERO_FRAMES = 32,
    parameter int unsigned LOSS64      = 6,
    parameter int unsigned SYNC64      = 5,
    parameter int unsigned LOSS48      = 5,
    parameter int unsigned SYNC48      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_clk,
    input  logic       short_frame,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       force_zero,
    output logic       proc_en
);

    localparam int unsigned CNT_W = $clog2(BASE * 4) + 1;
    localparam int unsigned ZW    = (ZERO_FRAMES > 1) ? $clog2(ZERO_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mon_state_e       state;
    logic             wc_d;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic             have_edge;
    logic             prev_hit;
    logic [1:0]       prev_code;
    logic [ZW-1:0]    zcnt;
    logic             hit;
    logic [1:0]       cls_code;
    logic             exceed;
    logic             calm;
    logic             late;

    assign rise = word_clk && !wc_d;

    // Edge detect register and cycles since the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wc_d <= 1'b0;
            cnt  <= '0;
        end else begin
            wc_d <= word_clk;
            if (rise)                cnt <= CNT_W'(1);
            else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    csm_ratio_classify #(
        .BASE  (BASE),
        .TOL   (TOL),
        .CNT_W (CNT_W)
    ) u_cls (
        .period (cnt),
        .hit    (hit),
        .code   (cls_code)
    );

    csm_drift_judge #(
        .BASE   (BASE),
        .CNT_W  (CNT_W),
        .LOSS64 (LOSS64),
        .SYNC64 (SYNC64),
        .LOSS48 (LOSS48),
        .SYNC48 (SYNC48)
    ) u_drift (
        .count       (cnt),
        .code        (ratio_code),
        .short_frame (short_frame),
        .exceed      (exceed),
        .calm        (calm),
        .late        (late)
    );

    // Acquire, mute, run and lost sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_ACQ;
            have_edge  <= 1'b0;
            prev_hit   <= 1'b0;
            prev_code  <= 2'd0;
            ratio_code <= 2'd0;
            zcnt       <= '0;
        end else begin
            case (state)
                ST_ACQ: begin
                    if (rise) begin
                        have_edge <= 1'b1;
                        if (have_edge) begin
                            prev_hit  <= hit;
                            prev_code <= cls_code;
                            if (hit && prev_hit && (cls_code == prev_code)) begin
                                ratio_code <= cls_code;
                                zcnt       <= '0;
                                state      <= ST_ZERO;
                            end
                        end
                    end
                end
                ST_ZERO: begin
                    if (exceed && (rise || late)) begin
                        state <= ST_LOST;
                    end else if (rise) begin
                        if (zcnt == ZW'(ZERO_FRAMES - 1)) state <= ST_RUN;
                        else                              zcnt  <= zcnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (exceed && (rise || late)) state <= ST_LOST;
                end
                default: begin
                    if (rise && calm) begin
                        zcnt  <= '0;
                        state <= ST_ZERO;
                    end
                end
            endcase
        end
    end

    assign locked     = (state == ST_ZERO) || (state == ST_RUN);
    assign force_zero = (state != ST_RUN);

    csm_rate_enable u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .active  (locked),
        .code    (ratio_code),
        .proc_en (proc_en)
    );

    AST_UNLOCKED_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> force_zero); // R5
    AST_RELEASE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_zero) |-> $past(locked)); // R4
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACQ) && ($past(state) != ST_ACQ) |-> $stable(ratio_code)); // R9
    AST_LATE_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && late && exceed |=> !locked); // R7

endmodule

// File: tb/clkratio_sync_mon_tb.sv
module clkratio_sync_mon_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_clk = 1'b0;
    logic       short_frame = 1'b0;
    logic [1:0] ratio_code;
    logic       locked;
    logic       force_zero;
    logic       proc_en;

    int tests = 0;
    int fails = 0;
    int en_seen = 0;

    always #4 clk = ~clk;

    clkratio_sync_mon u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_clk    (word_clk),
        .short_frame (short_frame),
        .ratio_code  (ratio_code),
        .locked      (locked),
        .force_zero  (force_zero),
        .proc_en     (proc_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One word-clock period of p cycles, counting enables over it.
    task automatic frame(input int p);
        en_seen = 0;
        for (int i = 0; i < p; i++) begin
            word_clk = (i < p / 2);
            en_seen += int'(proc_en);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic f48);
        rst_n = 1'b0;
        word_clk = 1'b0;
        short_frame = f48;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 locked in reset", int'(locked), 0);
        chk("R1 force_zero in reset", int'(force_zero), 1);
        chk("R1 proc_en in reset", int'(proc_en), 0);
        chk("R1 ratio in reset", int'(ratio_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 locked after reset", int'(locked), 0);
    endtask

    // Lock at period p, walk through the mute window, count enables.
    task automatic t_lock(input int p, input int code, input logic f48);
        do_reset(f48);
        repeat (3) frame(p);
        chk("R2 locked after two matching periods", int'(locked), 1);
        chk("R2 ratio code", int'(ratio_code), code);
        chk("R4 muted right after lock", int'(force_zero), 1);
        repeat (31) frame(p);
        chk("R4 muted after 31 edges", int'(force_zero), 1);
        frame(p);
        chk("R4 released on 32nd edge", int'(force_zero), 0);
        frame(p);
        chk("R3 enables per frame", en_seen, 256);
    endtask

    task automatic t_no_accept();
        do_reset(1'b0);
        repeat (3) frame(258);
        chk("R2 edge of window accepted", int'(locked), 1);
        do_reset(1'b0);
        repeat (5) frame(259);
        chk("R2 outside window rejected", int'(locked), 0);
        do_reset(1'b0);
        repeat (3) begin frame(384); frame(512); end
        chk("R2 alternating classes rejected", int'(locked), 0);
        chk("R3 no enable before lock", en_seen, 0);
    endtask

    task automatic t_hyst64();
        t_lock(256, 0, 1'b0);
        frame(280); frame(256);
        chk("R5 drift of 6 tolerated", int'(force_zero), 0);
        frame(281); frame(276);
        chk("R5 drift over 6 drops lock", int'(locked), 0);
        chk("R5 drift over 6 mutes", int'(force_zero), 1);
        frame(275);
        chk("R8 drift of 5 does not resync", int'(locked), 0);
        chk("R3 no enable while lost", en_seen, 0);
        chk("R9 ratio held while lost", int'(ratio_code), 0);
        frame(256);
        chk("R8 drift under 5 resyncs", int'(locked), 1);
        chk("R8 resync stays muted", int'(force_zero), 1);
        repeat (32) frame(256);
        chk("R4 release after resync", int'(force_zero), 0);
        frame(232); frame(256);
        chk("R5 short drift of 6 tolerated", int'(locked), 1);
        frame(231); frame(256);
        chk("R5 short drift over 6 drops lock", int'(locked), 0);
    endtask

    task automatic t_hyst48();
        t_lock(256, 0, 1'b1);
        frame(282); frame(256);
        chk("R6 48-bit drift under limit tolerated", int'(force_zero), 0);
        frame(283); frame(278);
        chk("R6 48-bit drift over 5 drops lock", int'(locked), 0);
        frame(277);
        chk("R8 48-bit drift of 4.1 no resync", int'(locked), 0);
        frame(256);
        chk("R8 48-bit drift under 4 resyncs", int'(locked), 1);
    endtask

    task automatic t_stall();
        t_lock(768, 3, 1'b0);
        word_clk = 1'b1;
        repeat (384) @(negedge clk);
        word_clk = 1'b0;
        repeat (460) @(negedge clk);
        chk("R7 stalled word clock drops lock", int'(locked), 0);
        chk("R7 stalled word clock mutes", int'(force_zero), 1);
        chk("R9 ratio held after stall", int'(ratio_code), 3);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_no_accept();
        t_lock(384, 1, 1'b0);
        t_lock(512, 2, 1'b0);
        t_hyst64();
        t_hyst48();
        t_stall();
        finish_up();
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

endmodule